// File: doc/BRIEF.md
# Interrupt claim/complete register file

This block gathers level-sensitive interrupt lines and presents their state to software through a 32-bit register bus. For every source it keeps a 3-bit priority, a pending bit and a claimed bit. For every context (one interrupt target) it keeps an enable bit per source and a priority threshold. From this state it drives, for each context, a vector of sources that are pending, not claimed, enabled and above that context's threshold.

An external selector picks one source per context from that vector and offers its ID on `sel_id_i`. A context takes an interrupt by reading its claim register: the read returns the offered ID, clears that source's pending bit and sets its claimed bit. A context releases the interrupt by writing the same ID back to the claim register.

The request side is a valid/ready channel. `bus_ready` is held high, so a request is accepted in every cycle in which `bus_valid` is high. A read answers with `rsp_valid` and `rsp_rdata` exactly one cycle later. A write produces no response. The response channel has no back-pressure: the requester must take the word in the cycle it is presented.

Top module: `irq_claim_rf`

## Requirements
- R1: After reset every priority, enable word, threshold, pending bit and claimed bit reads as zero, and `elig_o` is all zero.
- R2: `bus_ready` is always high. Each accepted read is answered by exactly one `rsp_valid` pulse in the next cycle. Writes never raise `rsp_valid`.
- R3: A request whose address has bits [1:0] not equal to zero, or that hits no register, changes no state. If it is a read, it returns 0.
- R4: The priority register of source s (1 to NUM_SRC-1) sits at PRIO_BASE + 4*(s-1). A write keeps only bits [2:0] of the data, and a read returns them zero-extended. Source 0 has no register.
- R5: Pending word w at PEND_BASE + 4*w holds source 32*w+b in bit b. The region is read-only, and writes to it are dropped.
- R6: Enable word w of context c sits at EN_BASE + c*EN_STRIDE + 4*w, with bit b enabling source 32*w+b. Words at w >= ceil(NUM_SRC/32) are unmapped.
- R7: The threshold of context c sits at CTX_BASE + c*CTX_STRIDE. A write is kept only when the 32-bit value is at most NUM_PRIO. A larger value leaves the old threshold in place.
- R8: A rising level on `src_i[s]` sets pending bit s, and a falling level clears it. A claim clears the bit, and it stays clear until the line next rises. `src_i[0]` is ignored.
- R9: `elig_o[c*NUM_SRC+s]` is high exactly when source s is pending, not claimed, enabled for context c, and its priority is strictly greater than the threshold of context c.
- R10: A read at offset 4 of a context's block returns the ID offered on that context's slice of `sel_id_i` if that source is eligible for the context, then clears its pending bit and sets its claimed bit. Otherwise the read returns 0 and changes nothing.
- R11: A write at offset 4 of a context's block clears the claimed bit of the ID in the data when the ID is below NUM_SRC. A larger value is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted; held high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| src_i | input | NUM_SRC | Level interrupt lines, bit 0 unused |
| sel_id_i | input | NCTX*IDW | Source ID offered by the selector for each context |
| elig_o | output | NCTX*NUM_SRC | Per-context eligible-source vectors |

## Verification
The assertions watch, on every cycle, the response timing of the bus, the zero data returned for misaligned reads, and two invariants. No source is eligible unless its input line was high at the last edge, and a source that a claim has just returned is no longer eligible in any context. Which register an address reaches, the 3-bit priority mask, the threshold limit, the stickiness of the cleared pending bit while a line stays high, and the release of a claim by a completion write are shown only by the bench. It does this through read-back and eligibility checks after each step of the scenario.

// File: rtl/irqrf_pkg.sv
package irqrf_pkg;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_PRIO,
    REG_PEND,
    REG_EN,
    REG_THR,
    REG_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] idx;   // source ID for priority, word index for pending/enable
    logic [7:0]  ctx;   // context for enable, threshold and claim
  } reg_sel_t;

endpackage

// File: rtl/irqrf_decode.sv
module irqrf_decode
  import irqrf_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NCTX       = 2,
  parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
  parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
  parameter logic [31:0] EN_BASE    = 32'h0000_2000,
  parameter logic [31:0] EN_STRIDE  = 32'h0000_0080,
  parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_1000
) (
  input  logic [31:0] addr,
  output reg_sel_t    sel
);

  localparam int unsigned NWORDS    = (NUM_SRC + 31) / 32;
  localparam int unsigned EN_SH     = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH    = $clog2(CTX_STRIDE);
  localparam logic [31:0] PRIO_SIZE = 32'((NUM_SRC - 1) * 4);
  localparam logic [31:0] PEND_SIZE = 32'(NWORDS * 4);
  localparam logic [31:0] EN_SIZE   = 32'(NCTX) * EN_STRIDE;
  localparam logic [31:0] CTX_SIZE  = 32'(NCTX) * CTX_STRIDE;

  logic [31:0] prio_off, pend_off, en_off, ctx_off;
  logic [31:0] en_word, ctx_sub;

  // Offsets wrap below a base, so one unsigned compare covers both bounds.
  assign prio_off = addr - PRIO_BASE;
  assign pend_off = addr - PEND_BASE;
  assign en_off   = addr - EN_BASE;
  assign ctx_off  = addr - CTX_BASE;
  assign en_word  = (en_off & (EN_STRIDE - 32'd1)) >> 2;
  assign ctx_sub  = ctx_off & (CTX_STRIDE - 32'd1);

  always_comb begin
    sel      = '0;
    sel.kind = REG_NONE;
    if (addr[1:0] == 2'b00) begin
      if (prio_off < PRIO_SIZE) begin
        sel.kind = REG_PRIO;
        sel.idx  = 16'(prio_off >> 2) + 16'd1;
      end else if (pend_off < PEND_SIZE) begin
        sel.kind = REG_PEND;
        sel.idx  = 16'(pend_off >> 2);
      end else if (en_off < EN_SIZE) begin
        if (en_word < 32'(NWORDS)) begin
          sel.kind = REG_EN;
          sel.idx  = 16'(en_word);
          sel.ctx  = 8'(en_off >> EN_SH);
        end
      end else if (ctx_off < CTX_SIZE) begin
        sel.ctx = 8'(ctx_off >> CTX_SH);
        if (ctx_sub == 32'd0) begin
          sel.kind = REG_THR;
        end else if (ctx_sub == 32'd4) begin
          sel.kind = REG_CLAIM;
        end
      end
    end
  end

endmodule

// File: rtl/irqrf_src_state.sv
module irqrf_src_state #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned IDW     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               claim_fire,
  input  logic [IDW-1:0]     claim_id,
  input  logic               done_fire,
  input  logic [IDW-1:0]     done_id,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] claimed
);

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise, fall;
  logic [NUM_SRC-1:0] pend_nxt, clm_nxt;

  assign rise = src_i & ~src_q;
  assign fall = ~src_i & src_q;

  always_comb begin
    pend_nxt    = (pending & ~fall) | rise;
    pend_nxt[0] = 1'b0;
    if (claim_fire) begin
      pend_nxt[claim_id] = 1'b0;  // a claim wins over a rise in the same cycle
    end
    clm_nxt = claimed;
    if (claim_fire) begin
      clm_nxt[claim_id] = 1'b1;
    end
    if (done_fire) begin
      clm_nxt[done_id] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      pending <= '0;
      claimed <= '0;
    end else begin
      src_q   <= src_i;
      pending <= pend_nxt;
      claimed <= clm_nxt;
    end
  end

endmodule

// File: rtl/irqrf_ctx.sv
module irqrf_ctx #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_PRIO = 7,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned NWORDS   = (NUM_SRC + 31) / 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_we,
  input  logic [15:0]               en_word,
  input  logic                      thr_we,
  input  logic [31:0]               wdata,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [NUM_SRC-1:0]        pending,
  input  logic [NUM_SRC-1:0]        claimed,
  output logic [NWORDS*32-1:0]      en_vec,
  output logic [PRIO_W-1:0]         thr,
  output logic [NUM_SRC-1:0]        elig
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_vec <= '0;
      thr    <= '0;
    end else begin
      if (en_we) begin
        en_vec[en_word*32 +: 32] <= wdata;
      end
      if (thr_we && (wdata <= 32'(NUM_PRIO))) begin
        thr <= wdata[PRIO_W-1:0];
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_reserved
      assign elig[s] = 1'b0;
    end else begin : g_live
      assign elig[s] = pending[s] & ~claimed[s] & en_vec[s] &
                       (prio[s*PRIO_W +: PRIO_W] > thr);
    end
  end

endmodule

// File: rtl/irq_claim_rf.sv
module irq_claim_rf
  import irqrf_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NCTX       = 2,
  parameter int unsigned NUM_PRIO   = 7,
  parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
  parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
  parameter logic [31:0] EN_BASE    = 32'h0000_2000,
  parameter logic [31:0] EN_STRIDE  = 32'h0000_0080,
  parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_1000,
  localparam int unsigned IDW       = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  output logic                     bus_ready,
  input  logic                     bus_write,
  input  logic [31:0]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  input  logic [NUM_SRC-1:0]       src_i,
  input  logic [NCTX*IDW-1:0]      sel_id_i,
  output logic [NCTX*NUM_SRC-1:0]  elig_o
);

  localparam int unsigned NWORDS = (NUM_SRC + 31) / 32;
  localparam int unsigned PRIO_W = 3;

  reg_sel_t                   sel;
  logic                       fire, rd_fire, wr_fire;
  logic [NUM_SRC*PRIO_W-1:0]  prio_q;
  logic [NUM_SRC-1:0]         pending, claimed;
  logic [NWORDS*32-1:0]       pend_pad;
  logic [NCTX*NWORDS*32-1:0]  en_flat;
  logic [NCTX*PRIO_W-1:0]     thr_flat;
  logic [NCTX*NUM_SRC-1:0]    elig_all;
  logic [IDW-1:0]             offered;
  logic                       offer_ok;
  logic                       claim_fire, done_fire;
  logic [IDW-1:0]             claim_id;
  logic [31:0]                rd_nxt;

  assign bus_ready = 1'b1;
  assign fire      = bus_valid & bus_ready;
  assign rd_fire   = fire & ~bus_write;
  assign wr_fire   = fire & bus_write;

  irqrf_decode #(
    .NUM_SRC(NUM_SRC), .NCTX(NCTX),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
    .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  // Priority registers; slot 0 is never written and stays zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr_fire && sel.kind == REG_PRIO) begin
      prio_q[sel.idx*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
    end
  end

  // Claim: accept the offered ID only when it is eligible for that context.
  assign offered    = sel_id_i[sel.ctx*IDW +: IDW];
  assign offer_ok   = elig_all[sel.ctx*NUM_SRC + 32'(offered)];
  assign claim_fire = rd_fire && (sel.kind == REG_CLAIM) && offer_ok;
  assign claim_id   = offered;
  assign done_fire  = wr_fire && (sel.kind == REG_CLAIM) && (bus_wdata < 32'(NUM_SRC));

  irqrf_src_state #(.NUM_SRC(NUM_SRC), .IDW(IDW)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .claim_fire (claim_fire),
    .claim_id   (claim_id),
    .done_fire  (done_fire),
    .done_id    (bus_wdata[IDW-1:0]),
    .pending    (pending),
    .claimed    (claimed)
  );

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic en_we, thr_we;
    assign en_we  = wr_fire && (sel.kind == REG_EN)  && (sel.ctx == 8'(c));
    assign thr_we = wr_fire && (sel.kind == REG_THR) && (sel.ctx == 8'(c));

    irqrf_ctx #(
      .NUM_SRC(NUM_SRC), .NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W), .NWORDS(NWORDS)
    ) u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_we   (en_we),
      .en_word (sel.idx),
      .thr_we  (thr_we),
      .wdata   (bus_wdata),
      .prio    (prio_q),
      .pending (pending),
      .claimed (claimed),
      .en_vec  (en_flat[c*NWORDS*32 +: NWORDS*32]),
      .thr     (thr_flat[c*PRIO_W +: PRIO_W]),
      .elig    (elig_all[c*NUM_SRC +: NUM_SRC])
    );
  end

  assign elig_o = elig_all;

  always_comb begin
    pend_pad               = '0;
    pend_pad[NUM_SRC-1:0]  = pending;
  end

  always_comb begin
    rd_nxt = '0;
    unique case (sel.kind)
      REG_PRIO:  rd_nxt = 32'(prio_q[sel.idx*PRIO_W +: PRIO_W]);
      REG_PEND:  rd_nxt = pend_pad[sel.idx*32 +: 32];
      REG_EN:    rd_nxt = en_flat[(sel.ctx*NWORDS + sel.idx)*32 +: 32];
      REG_THR:   rd_nxt = 32'(thr_flat[sel.ctx*PRIO_W +: PRIO_W]);
      REG_CLAIM: rd_nxt = offer_ok ? 32'(offered) : 32'd0;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_rdata <= rd_nxt;
      end
    end
  end

endmodule

// File: rtl/irqrf_checker.sv
module irqrf_checker #(
  parameter int unsigned NUM_SRC    = 32,
  parameter int unsigned NCTX       = 2,
  parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_1000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [31:0]             bus_addr,
  input logic                    rsp_valid,
  input logic [31:0]             rsp_rdata,
  input logic [NUM_SRC-1:0]      src_i,
  input logic [NCTX*NUM_SRC-1:0] elig_o
);

  localparam int unsigned IDW = $clog2(NUM_SRC);

  logic [31:0]             c_off;
  logic                    is_claim;
  logic                    claim_q;
  logic [NCTX*NUM_SRC-1:0] src_rep;
  logic                    id_hit;

  assign c_off    = bus_addr - CTX_BASE;
  assign is_claim = (c_off < 32'(NCTX) * CTX_STRIDE) &&
                    ((c_off & (CTX_STRIDE - 32'd1)) == 32'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) claim_q <= 1'b0;
    else        claim_q <= bus_valid && !bus_write && is_claim;
  end

  always_comb begin
    src_rep = '0;
    id_hit  = 1'b0;
    for (int c = 0; c < NCTX; c++) begin
      src_rep[c*NUM_SRC +: NUM_SRC] = src_i;
      id_hit = id_hit | elig_o[c*NUM_SRC + 32'(rsp_rdata[IDW-1:0])];
    end
  end

  // R2: a read is answered in the next cycle
  a_r2_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);

  // R2: no response without a read in the previous cycle
  a_r2_no_rsp_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rsp_valid);

  // R3: a misaligned read returns zero
  a_r3_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[1:0] != 2'b00) |=> (rsp_rdata == 32'd0));

  // R8 and R9: eligibility needs the source line high at the last edge
  a_r9_elig_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_o & ~$past(src_rep)) == '0);

  // R10: a source just returned by a claim is eligible nowhere
  a_r10_claimed_not_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && claim_q && rsp_rdata != 32'd0) |-> !id_hit);

endmodule

bind irq_claim_rf irqrf_checker #(
  .NUM_SRC(NUM_SRC), .NCTX(NCTX), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
) u_chk (.*);

// File: tb/irq_claim_rf_tb.sv
`timescale 1ns/1ps
module irq_claim_rf_tb;

  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned NCTX    = 2;
  localparam int unsigned IDW     = $clog2(NUM_SRC);
  localparam logic [31:0] PEND_A  = 32'h0000_1000;
  localparam logic [31:0] EN_A    = 32'h0000_2000;
  localparam logic [31:0] EN_STR  = 32'h0000_0080;
  localparam logic [31:0] CTX_A   = 32'h0020_0000;
  localparam logic [31:0] CTX_STR = 32'h0000_1000;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    bus_valid = 1'b0;
  logic                    bus_ready;
  logic                    bus_write = 1'b0;
  logic [31:0]             bus_addr = '0;
  logic [31:0]             bus_wdata = '0;
  logic                    rsp_valid;
  logic [31:0]             rsp_rdata;
  logic [NUM_SRC-1:0]      src_i = '0;
  logic [NCTX*IDW-1:0]     sel_id_i = '0;
  logic [NCTX*NUM_SRC-1:0] elig_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_claim_rf #(
    .NUM_SRC(NUM_SRC), .NCTX(NCTX), .NUM_PRIO(7),
    .PEND_BASE(PEND_A), .EN_BASE(EN_A), .EN_STRIDE(EN_STR),
    .CTX_BASE(CTX_A), .CTX_STRIDE(CTX_STR)
  ) u_dut (.*);

  function automatic logic [31:0] en_addr(int c, int w);
    return EN_A + 32'(c) * EN_STR + 32'(w * 4);
  endfunction

  function automatic logic [31:0] ctx_addr(int c, int off);
    return CTX_A + 32'(c) * CTX_STR + 32'(off);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares each response with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_errors++;
        $display("FAIL R2: actual=unexpected response %h expected=none", rsp_rdata);
      end else begin
        check(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    check("R2 write gives no response", 64'(rsp_valid), 64'd0);
  endtask

  task automatic bus_rd(logic [31:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    check("R2 ready held high", 64'(bus_ready), 64'd1);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic claim(int c, int offer, logic [31:0] exp, string tag);
    sel_id_i[c*IDW +: IDW] = IDW'(offer);
    bus_rd(ctx_addr(c, 4), exp, tag);
  endtask

  task automatic chk_elig(logic [31:0] c1, logic [31:0] c0, string tag);
    @(negedge clk);
    check(tag, 64'(elig_o), {c1, c0});
  endtask

  task automatic set_src(int s, logic v);
    @(negedge clk);
    src_i[s] = v;
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_elig(32'h0, 32'h0, "R1 elig after reset");
    bus_rd(32'h0, 32'h0, "R1 priority 1 reset");
    bus_rd(en_addr(0, 0), 32'h0, "R1 enable c0 reset");
    bus_rd(ctx_addr(1, 0), 32'h0, "R1 threshold c1 reset");
    bus_rd(PEND_A, 32'h0, "R1 pending reset");
    claim(0, 0, 32'h0, "R1 claim after reset");

    // R4: priorities keep 3 bits; offset k maps to source k+1
    bus_wr(32'h0, 32'hFF);
    bus_wr(32'h10, 32'h2A);
    bus_rd(32'h0, 32'h7, "R4 source 1 masked to 3 bits");
    bus_rd(32'h10, 32'h2, "R4 source 5 masked to 3 bits");
    bus_rd(32'h4, 32'h0, "R4 source 2 untouched");

    // R3: past the last priority, misaligned, unmapped
    bus_wr(32'h7C, 32'h5);
    bus_rd(32'h7C, 32'h0, "R3 slot past last source");
    bus_wr(32'h1, 32'h3);
    bus_rd(32'h0, 32'h7, "R3 misaligned write ignored");
    bus_rd(32'h1, 32'h0, "R3 misaligned read returns zero");
    bus_rd(32'h0000_0F00, 32'h0, "R3 unmapped read returns zero");

    // R6: enable words per context; word 1 is beyond the source count
    bus_wr(en_addr(0, 0), 32'h22);
    bus_wr(en_addr(1, 0), 32'h20);
    bus_wr(en_addr(0, 1), 32'hFFFF_FFFF);
    bus_rd(en_addr(0, 1), 32'h0, "R6 word past source count reads zero");
    bus_rd(en_addr(0, 0), 32'h22, "R6 enable c0 word 0");
    bus_rd(en_addr(1, 0), 32'h20, "R6 enable c1 word 0");

    // R7: threshold limit
    bus_wr(ctx_addr(1, 0), 32'h8);
    bus_rd(ctx_addr(1, 0), 32'h0, "R7 threshold above limit dropped");
    bus_wr(ctx_addr(1, 0), 32'h7);
    bus_rd(ctx_addr(1, 0), 32'h7, "R7 threshold at limit kept");
    bus_wr(ctx_addr(1, 0), 32'h1);
    bus_rd(ctx_addr(1, 0), 32'h1, "R7 threshold one");

    // R8, R5: rising lines set pending; line 0 ignored; pending read-only
    @(negedge clk);
    src_i[0] = 1'b1; src_i[1] = 1'b1; src_i[5] = 1'b1;
    bus_rd(PEND_A, 32'h22, "R8 rise sets pending, line 0 ignored");
    bus_wr(PEND_A, 32'h0);
    bus_rd(PEND_A, 32'h22, "R5 pending write dropped");
    // R9: eligibility per context
    chk_elig(32'h20, 32'h22, "R9 elig with two sources");

    // R10: claim and its side effects
    claim(0, 5, 32'h5, "R10 claim returns offered source");
    chk_elig(32'h0, 32'h02, "R10 claimed source leaves elig");
    claim(0, 5, 32'h0, "R10 claimed source not returned again");
    claim(1, 1, 32'h0, "R10 source not enabled for context");
    bus_rd(PEND_A, 32'h02, "R8 pending stays clear while line high");

    // R11: completion, then a new rise makes it eligible again
    bus_wr(ctx_addr(0, 4), 32'h5);
    chk_elig(32'h0, 32'h02, "R11 completion without new rise");
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    chk_elig(32'h20, 32'h22, "R11 released source eligible after rise");
    claim(1, 5, 32'h5, "R10 claim on context 1 above threshold");
    bus_wr(ctx_addr(1, 4), 32'h5);

    // R11: out-of-range completion ignored
    claim(0, 1, 32'h1, "R10 claim source 1");
    set_src(1, 1'b0);
    set_src(1, 1'b1);
    bus_rd(PEND_A, 32'h02, "R8 re-rise sets pending while claimed");
    chk_elig(32'h0, 32'h0, "R9 claimed source blocked");
    bus_wr(ctx_addr(0, 4), 32'd33);
    chk_elig(32'h0, 32'h0, "R11 completion with ID at or above count ignored");
    bus_wr(ctx_addr(0, 4), 32'd1);
    chk_elig(32'h0, 32'h02, "R11 completion releases source 1");

    // R8: falling line clears pending
    set_src(1, 1'b0);
    bus_rd(PEND_A, 32'h0, "R8 fall clears pending");
    chk_elig(32'h0, 32'h0, "R9 no pending no elig");

    // R9, R10: priority must exceed threshold
    bus_wr(ctx_addr(1, 0), 32'h2);
    set_src(5, 1'b0);
    set_src(5, 1'b1);
    chk_elig(32'h0, 32'h20, "R9 priority equal to threshold not eligible");
    claim(1, 5, 32'h0, "R10 claim below threshold returns zero");
    claim(0, 0, 32'h0, "R10 source 0 never claimed");
    bus_rd(PEND_A, 32'h20, "R10 failed claims leave pending");

    repeat (3) @(negedge clk);
    check("R2 every read answered", 64'(exp_q.size()), 64'd0);
    finish_up();
  end

endmodule